// File: doc/BRIEF.md
# Grouped Preemptive Interrupt Controller

This block gathers interrupt requests arranged in three priority groups of eight lines each. Each request line passes through its own enable bit into a pending register. An arbiter picks a winner from the pending set. Between groups the priority is fixed, and group 0 ranks highest. Inside a group, requests are served in rotating order. The winner's vector is placed in an in-service register, and a one-cycle trigger pulse announces it. The winning pending bit is cleared in the same step.

Preemption can be switched on by the host. While it is on, a request from a group that outranks the in-service group displaces the current vector. The displaced vector goes onto a three-entry stack. Once nothing of higher rank is left, the stack is unwound and each saved vector is issued again with a fresh pulse.

The host acknowledges an interrupt in one of three ways: by reading the in-service register, by writing the advance command, or by writing the full-reset command to the control register. A separate enable copies the trigger pulse onto an active-low bus interrupt line.

Top module: `grp_irq_ctrl`

## Requirements
- R1: A request line latches into its pending bit only when its `irq_mask` bit is 1. A request on a disabled line is ignored, and no vector results from it.
- R2: Between groups, priority is fixed. When requests from several groups are pending, the lowest group number is served first. Request line g*8+i belongs to group g, index i.
- R3: Inside one group, the search starts at the index after the last one served in that group and wraps around. The starting point after reset is index 0.
- R4: A pending request appears at `isr_out` one cycle after it is latched, as the vector {group[1:0], index[2:0]}. At the same time `irq_trig` is high for exactly one cycle, and the request's pending bit is cleared.
- R5: Whenever nothing is in service, and after reset, `isr_out` reads 5'h1F and `irq_trig` is 0.
- R6: While `preempt_en` is 0, the in-service vector does not change until the host acknowledges it, even if a higher-ranked request becomes pending.
- R7: While `preempt_en` is 1, a pending request whose group outranks the in-service group pushes the current vector onto the stack. The request's own vector is loaded, and the trigger fires again.
- R8: When the in-service register is freed and the stack is not empty, the top stacked vector is reissued with a trigger, provided no pending request outranks its group. If such a request exists, that request is served first.
- R9: A pulse on `host_rd_isr` acknowledges the in-service vector. If requests are pending, the next winner is loaded in the next cycle. Otherwise `isr_out` returns to 5'h1F.
- R10: A control write of 8'h20 acknowledges the in-service vector in the same way as a read. A control write of any value other than 8'h20 or 8'h10 has no effect.
- R11: A control write of 8'h10 empties the in-service register, all pending bits and the stack, and returns every group's rotation point to index 0.
- R12: `bus_irq_n` is low exactly when `busint_en` is 1 and `irq_trig` is high. Otherwise it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 24 | Request lines; line g*8+i is group g, index i |
| irq_mask | input | 24 | Per-line enable for latching requests |
| preempt_en | input | 1 | Allows higher-ranked requests to displace the in-service vector |
| busint_en | input | 1 | Routes the trigger to the bus interrupt line |
| host_rd_isr | input | 1 | Host read of the in-service register (acknowledge) |
| host_ctl_wr | input | 1 | Control register write strobe |
| host_ctl_data | input | 8 | Control write data: 8'h20 advance, 8'h10 full reset |
| isr_out | output | 5 | In-service vector, 5'h1F when idle |
| irq_trig | output | 1 | One-cycle pulse when a vector is loaded |
| bus_irq_n | output | 1 | Active-low bus interrupt request |

## Verification
The bench sends two requests on the same group, which exposes the rotation point. An arbiter that restarts at index 0 serves the lower index twice in a row, and one that skips the wrap-around misses the later index. It preempts a group 2 vector with a group 0 request and then acknowledges. A stack that fails to unwind leaves the register idle, and one that reissues too eagerly hides a higher-ranked pending request. The full-reset write is issued while a request is still pending. A design that leaves pending bits or rotation state behind loads a stale vector or serves in the wrong order. Long random runs mix acknowledges, masks and mode toggles against a cycle model, so an off-by-one-cycle trigger or a lost pending bit shows up as a miscompare.

// File: rtl/grp_irq_pkg.sv
`timescale 1ns/1ps
package grp_irq_pkg;
  // width of the group field inside a vector
  localparam int GRP_W = 2;

  // control register commands
  typedef enum logic [7:0] {
    CMD_ADVANCE = 8'h20,
    CMD_WIPE    = 8'h10
  } ctl_cmd_e;

  // group field of a vector with IW index bits
  function automatic logic [GRP_W-1:0] vec_group(input logic [7:0] vec, input int iw);
    return GRP_W'(vec >> iw);
  endfunction
endpackage

// File: rtl/grp_irq_pend.sv
`timescale 1ns/1ps
module grp_irq_pend #(
  parameter int NREQ = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] req,
  input  logic [NREQ-1:0] mask,
  input  logic [NREQ-1:0] clr_mask,
  input  logic            clr_all,
  output logic [NREQ-1:0] pend_q
);
  logic [NREQ-1:0] set_bits;
  assign set_bits = req & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (clr_all) pend_q <= '0;
    else              pend_q <= (pend_q & ~clr_mask) | set_bits;
  end

  // winning bit drops unless re-requested in the same cycle
  assert_win_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|clr_mask) && !clr_all) |=> ((pend_q & $past(clr_mask & ~set_bits)) == '0));

  assert_wipe_pending_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (pend_q == '0));
endmodule

// File: rtl/grp_irq_arb.sv
`timescale 1ns/1ps
module grp_irq_arb
  import grp_irq_pkg::*;
#(
  parameter int NGRP  = 3,
  parameter int GSIZE = 8,
  localparam int IDX_W = $clog2(GSIZE),
  localparam int NREQ  = NGRP * GSIZE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NREQ-1:0]  pend,
  input  logic             adv,
  input  logic             clr_all,
  output logic             win_v,
  output logic [GRP_W-1:0] win_g,
  output logic [IDX_W-1:0] win_i
);
  // rotating search: returns {found, index}
  function automatic logic [IDX_W:0] rr_pick(input logic [GSIZE-1:0] r,
                                             input logic [IDX_W-1:0] ptr);
    logic [IDX_W:0] res;
    res = '0;
    for (int k = GSIZE - 1; k >= 0; k--) begin
      int unsigned j;
      j = (int'(ptr) + k) % GSIZE;
      if (r[j]) res = {1'b1, IDX_W'(j)};
    end
    return res;
  endfunction

  function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] i);
    return IDX_W'((int'(i) + 1) % GSIZE);
  endfunction

  logic [IDX_W-1:0] rr_q  [NGRP];
  logic             g_hit [NGRP];
  logic [IDX_W-1:0] g_idx [NGRP];

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [IDX_W:0] pick;
    assign pick     = rr_pick(pend[g*GSIZE +: GSIZE], rr_q[g]);
    assign g_hit[g] = pick[IDX_W];
    assign g_idx[g] = pick[IDX_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  rr_q[g] <= '0;
      else if (clr_all)                            rr_q[g] <= '0;
      else if (adv && win_g == GRP_W'(g))          rr_q[g] <= next_idx(win_i);
    end
  end

  // fixed priority across groups, group 0 highest
  always_comb begin
    win_v = 1'b0;
    win_g = '0;
    win_i = '0;
    for (int g = NGRP - 1; g >= 0; g--) begin
      if (g_hit[g]) begin
        win_v = 1'b1;
        win_g = GRP_W'(g);
        win_i = g_idx[g];
      end
    end
  end

  assert_win_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    win_v |-> pend[int'(win_g)*GSIZE + int'(win_i)]);
endmodule

// File: rtl/grp_irq_stack.sv
`timescale 1ns/1ps
module grp_irq_stack #(
  parameter int DEPTH = 3,
  parameter int VEC_W = 5,
  localparam int SP_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             clr,
  input  logic [VEC_W-1:0] din,
  output logic [VEC_W-1:0] top,
  output logic             empty,
  output logic             full
);
  logic [VEC_W-1:0] mem [DEPTH];
  logic [SP_W-1:0]  sp_q;

  assign empty = (sp_q == '0);
  assign full  = (sp_q == SP_W'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sp_q <= '0;
    else if (clr)    sp_q <= '0;
    else if (push)   sp_q <= sp_q + 1'b1;
    else if (pop)    sp_q <= sp_q - 1'b1;
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              mem[e] <= '0;
      else if (push && sp_q == SP_W'(e))       mem[e] <= din;
    end
  end

  always_comb begin
    top = '0;
    for (int e = 0; e < DEPTH; e++)
      if (sp_q == SP_W'(e + 1)) top = mem[e];
  end

  // one entry per group with strictly rising rank: never fills up
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
endmodule

// File: rtl/grp_irq_ctrl.sv
`timescale 1ns/1ps
module grp_irq_ctrl
  import grp_irq_pkg::*;
#(
  parameter int NGRP  = 3,
  parameter int GSIZE = 8,
  localparam int IDX_W = $clog2(GSIZE),
  localparam int VEC_W = GRP_W + IDX_W,
  localparam int NREQ  = NGRP * GSIZE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NREQ-1:0]  irq_req,
  input  logic [NREQ-1:0]  irq_mask,
  input  logic             preempt_en,
  input  logic             busint_en,
  input  logic             host_rd_isr,
  input  logic             host_ctl_wr,
  input  logic [7:0]       host_ctl_data,
  output logic [VEC_W-1:0] isr_out,
  output logic             irq_trig,
  output logic             bus_irq_n
);
  // named internal events
  logic             clr_all, ack, isr_free;
  logic             win_v, pop_ev, push_ev, take_free, take;
  logic [GRP_W-1:0] win_g, cur_grp, top_grp;
  logic [IDX_W-1:0] win_i;
  logic [VEC_W-1:0] win_vec, stk_top;
  logic             stk_empty, stk_full;
  logic [NREQ-1:0]  pend_q, clr_mask;
  logic             isr_valid;
  logic [VEC_W-1:0] isr_vec;

  assign clr_all = host_ctl_wr && (host_ctl_data == CMD_WIPE);
  assign ack     = !clr_all &&
                   (host_rd_isr || (host_ctl_wr && host_ctl_data == CMD_ADVANCE));
  assign isr_free = !isr_valid || ack;

  assign win_vec = {win_g, win_i};
  assign cur_grp = vec_group(8'(isr_vec), IDX_W);
  assign top_grp = vec_group(8'(stk_top), IDX_W);

  assign pop_ev    = !clr_all && isr_free && !stk_empty && !(win_v && win_g < top_grp);
  assign take_free = !clr_all && isr_free && !pop_ev && win_v;
  assign push_ev   = !clr_all && !isr_free && preempt_en && win_v && (win_g < cur_grp);
  assign take      = take_free || push_ev;

  always_comb begin
    clr_mask = '0;
    if (take) clr_mask[int'(win_g)*GSIZE + int'(win_i)] = 1'b1;
  end

  grp_irq_pend #(.NREQ(NREQ)) u_pend (
    .clk, .rst_n, .req(irq_req), .mask(irq_mask),
    .clr_mask, .clr_all, .pend_q
  );

  grp_irq_arb #(.NGRP(NGRP), .GSIZE(GSIZE)) u_arb (
    .clk, .rst_n, .pend(pend_q), .adv(take), .clr_all,
    .win_v, .win_g, .win_i
  );

  grp_irq_stack #(.DEPTH(NGRP), .VEC_W(VEC_W)) u_stk (
    .clk, .rst_n, .push(push_ev), .pop(pop_ev), .clr(clr_all),
    .din(isr_vec), .top(stk_top), .empty(stk_empty), .full(stk_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_valid <= 1'b0;
      isr_vec   <= '1;
      irq_trig  <= 1'b0;
    end else if (clr_all) begin
      isr_valid <= 1'b0;
      irq_trig  <= 1'b0;
    end else begin
      irq_trig <= take || pop_ev;
      if (pop_ev) begin
        isr_valid <= 1'b1;
        isr_vec   <= stk_top;
      end else if (take) begin
        isr_valid <= 1'b1;
        isr_vec   <= win_vec;
      end else if (isr_free) begin
        isr_valid <= 1'b0;
      end
    end
  end

  assign isr_out   = isr_valid ? isr_vec : '1;
  assign bus_irq_n = ~(busint_en & irq_trig);

  assert_trig_loaded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_trig |-> isr_valid);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_valid && !preempt_en && !ack && !clr_all) |=> ($stable(isr_vec) && isr_valid));

  assert_push_rank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push_ev |=> (cur_grp < top_grp));

  assert_push_pop_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push_ev, pop_ev}));

  assert_wipe_isr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (!isr_valid && !irq_trig));

  assert_stack_unused_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!preempt_en && stk_empty && !clr_all) |=> stk_empty);

  // full flag only observed by the checker
  logic unused_full;
  assign unused_full = stk_full;
endmodule

// File: tb/sim_grp_irq_ctrl.sv
`timescale 1ns/1ps
module sim_grp_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] irq = '0, msk = '1;
  logic        pre = 1'b0, ben = 1'b0, rd = 1'b0, cw = 1'b0;
  logic [7:0]  cd = '0;
  logic [4:0]  isr_out;
  logic        irq_trig, bus_irq_n;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  grp_irq_ctrl u0 (
    .clk, .rst_n, .irq_req(irq), .irq_mask(msk), .preempt_en(pre),
    .busint_en(ben), .host_rd_isr(rd), .host_ctl_wr(cw), .host_ctl_data(cd),
    .isr_out, .irq_trig, .bus_irq_n
  );

  // cycle model
  logic [23:0] m_p;
  int          m_rr [3];
  logic [4:0]  m_stk [3];
  int          m_sp;
  bit          m_iv, m_tr;
  logic [4:0]  m_vec;

  function automatic void m_reset();
    m_p = '0; m_rr = '{0, 0, 0}; m_sp = 0; m_iv = 0; m_tr = 0; m_vec = 5'h1f;
  endfunction

  function automatic void m_pick(output bit v, output int g, output int i);
    v = 0; g = 0; i = 0;
    for (int gg = 0; gg < 3 && !v; gg++)
      for (int k = 0; k < 8 && !v; k++) begin
        int ix;
        ix = (m_rr[gg] + k) % 8;
        if (m_p[gg*8 + ix]) begin v = 1; g = gg; i = ix; end
      end
  endfunction

  function automatic void m_step();
    bit ca, ak, fr, wv, pop, tk, psh;
    int wg, wi;
    logic [23:0] clr;
    ca = cw && cd == 8'h10;
    ak = !ca && (rd || (cw && cd == 8'h20));
    m_pick(wv, wg, wi);
    if (ca) begin m_reset(); return; end
    fr = !m_iv || ak; pop = 0; tk = 0; psh = 0;
    if (fr) begin
      if (m_sp > 0 && !(wv && wg < int'(m_stk[m_sp-1][4:3]))) pop = 1;
      else if (wv) tk = 1;
    end else if (pre && wv && wg < int'(m_vec[4:3])) begin
      psh = 1; tk = 1;
    end
    clr = '0;
    if (tk) begin clr[wg*8 + wi] = 1'b1; m_rr[wg] = (wi + 1) % 8; end
    if (psh) begin m_stk[m_sp] = m_vec; m_sp++; end
    if (pop) begin m_sp--; m_vec = m_stk[m_sp]; m_iv = 1; end
    else if (tk) begin m_vec = {2'(wg), 3'(wi)}; m_iv = 1; end
    else if (fr) m_iv = 0;
    m_tr = pop || tk;
    m_p = (m_p & ~clr) | (irq & msk);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock with model compare
  task automatic cyc(string req);
    logic [6:0] e;
    m_step();
    @(posedge clk); #1;
    e = {m_iv ? m_vec : 5'h1f, 1'(m_tr), 1'(!(ben && m_tr))};
    check(req, {25'd0, isr_out, irq_trig, bus_irq_n}, {25'd0, e});
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) cyc("R4");
  endtask
  task automatic hit(logic [23:0] b);
    irq = b; cyc("R1"); irq = '0;
  endtask
  task automatic rd_ack();
    rd = 1; cyc("R9"); rd = 0;
  endtask
  task automatic wr(logic [7:0] v);
    cw = 1; cd = v; cyc("R10"); cw = 0; cd = '0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check("R5", {27'd0, isr_out}, 32'h1f);
    check("R5", {31'd0, irq_trig}, 0);
    check("R12", {31'd0, bus_irq_n}, 1);

    // R1: disabled line is ignored
    msk = ~24'h8; hit(24'h8); idle(2);
    check("R1", {27'd0, isr_out}, 32'h1f);
    msk = '1;

    // R2: group 0 before group 2
    hit(24'h1 << 19 | 24'h1 << 5); idle(1);
    check("R2", {27'd0, isr_out}, 32'h05);
    check("R4", {31'd0, irq_trig}, 1);
    idle(1);
    check("R4", {31'd0, irq_trig}, 0);
    check("R6", {27'd0, isr_out}, 32'h05);
    rd_ack();
    check("R9", {27'd0, isr_out}, 32'h13);
    rd_ack();
    check("R9", {27'd0, isr_out}, 32'h1f);

    // R3: rotation inside group 1
    wr(8'h10);
    hit(24'h1 << 9 | 24'h1 << 12); idle(1);
    check("R3", {27'd0, isr_out}, 32'h09);
    rd_ack();
    check("R3", {27'd0, isr_out}, 32'h0c);
    rd_ack();
    hit(24'h1 << 12 | 24'h1 << 14); idle(1);
    check("R3", {27'd0, isr_out}, 32'h0e);
    rd_ack();
    check("R3", {27'd0, isr_out}, 32'h0c);
    rd_ack();

    // R11: wipe resets rotation and pending
    wr(8'h10);
    hit(24'h1 << 12 | 24'h1 << 14); idle(1);
    check("R11", {27'd0, isr_out}, 32'h0c);
    wr(8'h10);
    check("R11", {27'd0, isr_out}, 32'h1f);
    idle(2);
    check("R11", {27'd0, isr_out}, 32'h1f);

    // R10: advance command and ignored values
    hit(24'h1 << 17); idle(1);
    wr(8'h33);
    check("R10", {27'd0, isr_out}, 32'h11);
    wr(8'h20);
    check("R10", {27'd0, isr_out}, 32'h1f);

    // R6: no preemption
    pre = 0;
    hit(24'h1 << 17); idle(1);
    hit(24'h1); idle(2);
    check("R6", {27'd0, isr_out}, 32'h11);
    rd_ack();
    check("R9", {27'd0, isr_out}, 32'h00);
    rd_ack();

    // R7 / R8: preempt and unwind
    pre = 1;
    hit(24'h1 << 16); idle(1);
    check("R7", {27'd0, isr_out}, 32'h10);
    hit(24'h1 << 2); idle(1);
    check("R7", {27'd0, isr_out}, 32'h02);
    check("R7", {31'd0, irq_trig}, 1);
    rd_ack();
    check("R8", {27'd0, isr_out}, 32'h10);
    check("R8", {31'd0, irq_trig}, 1);
    rd_ack();
    check("R8", {27'd0, isr_out}, 32'h1f);

    // R8: higher pending served before the stacked vector
    hit(24'h1 << 21); idle(1);
    hit(24'h1 << 11); idle(1);
    check("R7", {27'd0, isr_out}, 32'h0b);
    hit(24'h1 << 1);
    rd_ack();
    check("R8", {27'd0, isr_out}, 32'h01);
    rd_ack();
    check("R8", {27'd0, isr_out}, 32'h15);
    rd_ack();
    pre = 0;

    // R12: bus line
    ben = 1;
    hit(24'h1 << 5); idle(1);
    check("R12", {31'd0, bus_irq_n}, 0);
    idle(1);
    check("R12", {31'd0, bus_irq_n}, 1);
    rd_ack();
    ben = 0;
    hit(24'h1 << 5); idle(1);
    check("R12", {31'd0, bus_irq_n}, 1);
    rd_ack();

    // random traffic against the model
    for (int c = 0; c < 4000; c++) begin
      int r;
      irq = ($urandom % 5 == 0) ? (24'h1 << ($urandom % 24)) : '0;
      if ($urandom % 9 == 0) irq = irq | (24'h1 << ($urandom % 24));
      msk = ($urandom % 8 == 0) ? 24'($urandom) : '1;
      rd  = ($urandom % 6 == 0);
      cw  = ($urandom % 30 == 0);
      r   = $urandom % 10;
      cd  = (r < 6) ? 8'h20 : (r < 7) ? 8'h10 : 8'($urandom);
      ben = 1'($urandom);
      if (c % 600 == 0) pre = ~pre;
      cyc("R2 R3 R4 R7 R8");
    end
    irq = '0; rd = 0; cw = 0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule